// File: doc/BRIEF.md
# Single-Bit Set, Clear and Test Unit

This block carries out the one-bit instructions of a small nibble-wide controller core. A sequencer passes it an opcode of one or two bytes, along with the current accumulator, the HL pointer and the LR register. The unit reads the selected nibble from the RAM, the port bank or the accumulator. It then writes the nibble back with a single bit forced, or loads the status flag from one bit. The carry and zero flags are never touched.

An instruction addresses its nibble in one of three ways:
- through HL, which points into RAM;
- directly, with a 4-bit address field in the second byte;
- through LR, where the upper pair of LR bits selects port 4 to 7 and the lower pair selects the bit.

Test operations come in two senses. One loads the flag with the inverted bit and the other loads the bit as it is. In the cycle after it accepts an instruction, the unit reports the byte length and the cycle cost of that instruction back to the sequencer. Opcodes outside the bit group are refused with a one-cycle not-mine pulse.

Every accepted instruction follows the same three-cycle sequence, and the RAM and ports are read with registered (synchronous) reads. The cycle cost reported to the sequencer is the cost of the instruction in the core's timing. It is not the latency of this unit.

Top module: `bitop_unit`

## Requirements
- R1: One-byte opcode 1111 oo bb with oo=00 clears and oo=01 sets bit bb of RAM[HL]. Only that bit of the nibble changes, and the write goes to the address that was read.
- R2: One-byte opcode 1111 oo bb with oo=10 loads the status flag with the inverse of accumulator bit bb, and oo=11 loads it with the inverse of RAM[HL] bit bb. Neither form writes memory.
- R3: First byte 0110 1100 with second byte oo bb yyyy acts on RAM address yyyy, zero-extended: oo=00 tests inverted, 01 sets, 10 tests true, 11 clears bit bb.
- R4: First byte 0110 1101 with second byte oo bb pppp applies the same four operations to port pppp.
- R5: Opcodes 0110 0000 (clear), 0110 0010 (set) and 0110 0001 (inverted test) act on port LR[3:2]+4, bit LR[1:0].
- R6: Set and clear load the status flag with 1. An inverted test loads the complement of the bit and a true test loads the bit. The carry and zero write enables are never raised.
- R7: In the cycle after acceptance, info_valid pulses with the length and cycle count: HL and accumulator forms 1 byte / 1 cycle, LR forms 1 byte / 2 cycles, direct forms 2 bytes / 2 cycles.
- R8: The read strobe and address appear in the cycle after acceptance. The write strobe, done and the status-flag write appear two cycles later, with the address held throughout. busy is high from acceptance until done.
- R9: An opcode outside the bit group produces a one-cycle not_mine pulse. It raises no strobe, no done and no flag write, and it leaves RAM, ports and the flag unchanged.
- R10: A start seen while busy is ignored.
- R11: During reset, all strobes, pulses and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction offered; taken when not busy |
| op0 | input | 8 | First opcode byte |
| op1 | input | 8 | Second opcode byte (direct forms) |
| acc | input | 4 | Accumulator value |
| hl | input | RAM_AW | HL pointer |
| lr | input | 4 | LR register |
| busy | output | 1 | Instruction in progress |
| not_mine | output | 1 | Opcode refused (one-cycle pulse) |
| info_valid | output | 1 | Length and cycle report valid |
| info_len | output | 2 | Instruction length in bytes |
| info_cyc | output | 2 | Instruction cycle count |
| done | output | 1 | Final cycle of instruction |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM address for read and write |
| ram_wdata | output | 4 | RAM write nibble |
| ram_rdata | input | 4 | RAM read nibble, one cycle after the read |
| port_re | output | 1 | Port read strobe |
| port_we | output | 1 | Port write strobe |
| port_addr | output | PORT_AW | Port number |
| port_wdata | output | 4 | Port write nibble |
| port_rdata | input | 4 | Port read nibble, one cycle after the read |
| sf_we | output | 1 | Status flag write |
| sf_d | output | 1 | New status flag value |
| cf_we | output | 1 | Carry flag write (never raised) |
| zf_we | output | 1 | Zero flag write (never raised) |

## Verification
Each operation is applied at bit positions 0 and 3 and on nibbles where the target bit already holds the forced value. This separates a correct single-bit mask from a whole-nibble write, and a real set or clear from a write that merely leaves the nibble as it was. The inverted and true tests run on both 0 and 1 bits, so a swapped polarity shows up. The HL extremes, direct addresses and several LR values confirm that the three addressing paths and the port offset of 4 select the right nibble. Unknown opcodes, and starts held high during busy, are followed by a full comparison of RAM, ports and flag against the bench's reference copy.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int NIB_W = 4;
  localparam int BIX_W = 2;

  typedef enum logic [1:0] {
    BOP_CLR  = 2'd0,
    BOP_SET  = 2'd1,
    BOP_TSTF = 2'd2,
    BOP_TSTT = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_PORT = 2'd1,
    SRC_ACC  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    AM_HL     = 2'd0,
    AM_DIRECT = 2'd1,
    AM_LR     = 2'd2
  } amode_e;

  typedef struct packed {
    logic             legal;
    bop_e             op;
    src_e             src;
    amode_e           am;
    logic [3:0]       dir;
    logic [BIX_W-1:0] bix;
    logic [1:0]       len;
    logic [1:0]       cyc;
  } dec_t;

  // Operation field of the two-byte forms
  function automatic bop_e pair_op(input logic [1:0] oo);
    case (oo)
      2'b00:   return BOP_TSTF;
      2'b01:   return BOP_SET;
      2'b10:   return BOP_TSTT;
      default: return BOP_CLR;
    endcase
  endfunction

  function automatic logic [NIB_W-1:0] bit_mask(input logic [BIX_W-1:0] b);
    return NIB_W'(1) << b;
  endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [7:0] op0,
  input  logic [7:0] op1,
  output dec_t       dec
);

  always_comb begin
    dec       = '0;
    dec.op    = BOP_CLR;
    dec.src   = SRC_RAM;
    dec.am    = AM_HL;
    if (op0[7:4] == 4'hF) begin
      dec.legal = 1'b1;
      dec.am    = AM_HL;
      dec.bix   = op0[1:0];
      dec.len   = 2'd1;
      dec.cyc   = 2'd1;
      case (op0[3:2])
        2'b00:   begin dec.op = BOP_CLR;  dec.src = SRC_RAM; end
        2'b01:   begin dec.op = BOP_SET;  dec.src = SRC_RAM; end
        2'b10:   begin dec.op = BOP_TSTF; dec.src = SRC_ACC; end
        default: begin dec.op = BOP_TSTF; dec.src = SRC_RAM; end
      endcase
    end else if (op0 == 8'h6C || op0 == 8'h6D) begin
      dec.legal = 1'b1;
      dec.am    = AM_DIRECT;
      dec.op    = pair_op(op1[7:6]);
      dec.bix   = op1[5:4];
      dec.dir   = op1[3:0];
      dec.src   = op0[0] ? SRC_PORT : SRC_RAM;
      dec.len   = 2'd2;
      dec.cyc   = 2'd2;
    end else if (op0 == 8'h60 || op0 == 8'h61 || op0 == 8'h62) begin
      dec.legal = 1'b1;
      dec.am    = AM_LR;
      dec.src   = SRC_PORT;
      dec.len   = 2'd1;
      dec.cyc   = 2'd2;
      case (op0[1:0])
        2'b00:   dec.op = BOP_CLR;
        2'b10:   dec.op = BOP_SET;
        default: dec.op = BOP_TSTF;
      endcase
    end
  end

endmodule

// File: rtl/bitop_addr.sv
module bitop_addr
  import bitop_pkg::*;
#(
  parameter int RAM_AW  = 6,
  parameter int PORT_AW = 4
) (
  input  dec_t               dec,
  input  logic [RAM_AW-1:0]  hl,
  input  logic [3:0]         lr,
  output logic [RAM_AW-1:0]  ram_a,
  output logic [PORT_AW-1:0] port_a,
  output logic [BIX_W-1:0]   bix
);

  // LR page: ports 4..7 selected by the upper LR pair
  localparam logic [2:0] LR_BASE = 3'd4;

  logic [2:0] lr_port;

  always_comb begin
    lr_port = LR_BASE + {1'b0, lr[3:2]};
    ram_a   = (dec.am == AM_HL) ? hl : RAM_AW'(dec.dir);
    port_a  = (dec.am == AM_LR) ? PORT_AW'(lr_port) : PORT_AW'(dec.dir);
    bix     = (dec.am == AM_LR) ? lr[1:0] : dec.bix;
  end

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
  import bitop_pkg::*;
(
  input  bop_e             op,
  input  src_e             src,
  input  logic [BIX_W-1:0] bix,
  input  logic [NIB_W-1:0] acc_v,
  input  logic [NIB_W-1:0] ram_v,
  input  logic [NIB_W-1:0] port_v,
  output logic [NIB_W-1:0] wdata,
  output logic             flag,
  output logic             is_write
);

  logic [NIB_W-1:0] src_v;
  logic [NIB_W-1:0] mask;
  logic             bitv;

  always_comb begin
    case (src)
      SRC_RAM:  src_v = ram_v;
      SRC_PORT: src_v = port_v;
      default:  src_v = acc_v;
    endcase
    mask     = bit_mask(bix);
    bitv     = |(src_v & mask);
    wdata    = src_v;
    flag     = 1'b1;
    is_write = 1'b0;
    case (op)
      BOP_CLR:  begin wdata = src_v & ~mask; is_write = 1'b1; end
      BOP_SET:  begin wdata = src_v | mask;  is_write = 1'b1; end
      BOP_TSTF: flag = ~bitv;
      default:  flag = bitv;
    endcase
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int RAM_AW  = 6,
  parameter int PORT_AW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         op0,
  input  logic [7:0]         op1,
  input  logic [3:0]         acc,
  input  logic [RAM_AW-1:0]  hl,
  input  logic [3:0]         lr,
  output logic               busy,
  output logic               not_mine,
  output logic               info_valid,
  output logic [1:0]         info_len,
  output logic [1:0]         info_cyc,
  output logic               done,
  output logic               ram_re,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic [3:0]         ram_wdata,
  input  logic [3:0]         ram_rdata,
  output logic               port_re,
  output logic               port_we,
  output logic [PORT_AW-1:0] port_addr,
  output logic [3:0]         port_wdata,
  input  logic [3:0]         port_rdata,
  output logic               sf_we,
  output logic               sf_d,
  output logic               cf_we,
  output logic               zf_we
);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_EX} st_e;

  st_e              st_q;
  dec_t             dec_n;
  logic [RAM_AW-1:0]  ram_a_n;
  logic [PORT_AW-1:0] port_a_n;
  logic [BIX_W-1:0]   bix_n;

  bop_e             op_q;
  src_e             src_q;
  logic [BIX_W-1:0] bix_q;
  logic [NIB_W-1:0] acc_q;
  logic [NIB_W-1:0] wd_q;

  logic [NIB_W-1:0] wdata_n;
  logic             flag_n;
  logic             wr_n;

  bitop_decode u_dec (
    .op0 (op0),
    .op1 (op1),
    .dec (dec_n)
  );

  bitop_addr #(
    .RAM_AW  (RAM_AW),
    .PORT_AW (PORT_AW)
  ) u_addr (
    .dec    (dec_n),
    .hl     (hl),
    .lr     (lr),
    .ram_a  (ram_a_n),
    .port_a (port_a_n),
    .bix    (bix_n)
  );

  bitop_exec u_exec (
    .op       (op_q),
    .src      (src_q),
    .bix      (bix_q),
    .acc_v    (acc_q),
    .ram_v    (ram_rdata),
    .port_v   (port_rdata),
    .wdata    (wdata_n),
    .flag     (flag_n),
    .is_write (wr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      op_q       <= BOP_CLR;
      src_q      <= SRC_RAM;
      bix_q      <= '0;
      acc_q      <= '0;
      wd_q       <= '0;
      not_mine   <= 1'b0;
      info_valid <= 1'b0;
      info_len   <= '0;
      info_cyc   <= '0;
      done       <= 1'b0;
      ram_re     <= 1'b0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      port_re    <= 1'b0;
      port_we    <= 1'b0;
      port_addr  <= '0;
      sf_we      <= 1'b0;
      sf_d       <= 1'b0;
    end else begin
      not_mine   <= 1'b0;
      info_valid <= 1'b0;
      done       <= 1'b0;
      ram_re     <= 1'b0;
      ram_we     <= 1'b0;
      port_re    <= 1'b0;
      port_we    <= 1'b0;
      sf_we      <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (dec_n.legal) begin
              st_q       <= ST_RD;
              op_q       <= dec_n.op;
              src_q      <= dec_n.src;
              bix_q      <= bix_n;
              acc_q      <= acc;
              info_valid <= 1'b1;
              info_len   <= dec_n.len;
              info_cyc   <= dec_n.cyc;
              if (dec_n.src == SRC_RAM) begin
                ram_re   <= 1'b1;
                ram_addr <= ram_a_n;
              end
              if (dec_n.src == SRC_PORT) begin
                port_re   <= 1'b1;
                port_addr <= port_a_n;
              end
            end else begin
              not_mine <= 1'b1;
            end
          end
        end
        ST_RD: st_q <= ST_EX;
        default: begin
          st_q    <= ST_IDLE;
          done    <= 1'b1;
          sf_we   <= 1'b1;
          sf_d    <= flag_n;
          wd_q    <= wdata_n;
          ram_we  <= wr_n && (src_q == SRC_RAM);
          port_we <= wr_n && (src_q == SRC_PORT);
        end
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign ram_wdata  = wd_q;
  assign port_wdata = wd_q;
  assign cf_we      = 1'b0;
  assign zf_we      = 1'b0;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int RAM_AW  = 6,
  parameter int PORT_AW = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               not_mine,
  input logic               info_valid,
  input logic               ram_re,
  input logic               ram_we,
  input logic [RAM_AW-1:0]  ram_addr,
  input logic [3:0]         ram_wdata,
  input logic [3:0]         ram_rdata,
  input logic               port_re,
  input logic               port_we,
  input logic [PORT_AW-1:0] port_addr,
  input logic [3:0]         port_wdata,
  input logic [3:0]         port_rdata
);

  AST_RAM_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(ram_re, 2)); // R8

  AST_PORT_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    port_we |-> $past(port_re, 2)); // R8

  AST_RAM_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_addr == $past(ram_addr, 2)); // R1

  AST_PORT_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    port_we |-> port_addr == $past(port_addr, 2)); // R4

  AST_RAM_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $countones(ram_wdata ^ $past(ram_rdata)) <= 1); // R1

  AST_PORT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    port_we |-> $countones(port_wdata ^ $past(port_rdata)) <= 1); // R5

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, port_we})); // R8

  AST_DONE_AFTER_INFO: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(info_valid, 2)); // R7

  AST_BUSY_REPORTS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> info_valid); // R7

  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    not_mine |-> !busy && !ram_re && !port_re && !info_valid); // R9

endmodule

bind bitop_unit bitop_unit_chk #(
  .RAM_AW  (RAM_AW),
  .PORT_AW (PORT_AW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .not_mine   (not_mine),
  .info_valid (info_valid),
  .ram_re     (ram_re),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .ram_wdata  (ram_wdata),
  .ram_rdata  (ram_rdata),
  .port_re    (port_re),
  .port_we    (port_we),
  .port_addr  (port_addr),
  .port_wdata (port_wdata),
  .port_rdata (port_rdata)
);

// File: tb/bitop_unit_test.sv
module bitop_unit_test;

  localparam int RAM_AW  = 6;
  localparam int PORT_AW = 4;
  localparam int RAM_N   = 1 << RAM_AW;
  localparam int PORT_N  = 1 << PORT_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] op0_i = '0, op1_i = '0;
  logic [3:0] acc_i = '0, lr_i = '0;
  logic [RAM_AW-1:0] hl_i = '0;

  logic busy, not_mine, info_valid, done;
  logic [1:0] info_len, info_cyc;
  logic ram_re, ram_we, port_re, port_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [PORT_AW-1:0] port_addr;
  logic [3:0] ram_wdata, port_wdata;
  logic [3:0] ram_rdata = '0, port_rdata = '0;
  logic sf_we, sf_d, cf_we, zf_we;

  logic [3:0] ram_mem [RAM_N];
  logic [3:0] port_mem [PORT_N];
  logic       sf_reg = 1'b0;

  logic [3:0] m_ram [RAM_N];
  logic [3:0] m_port [PORT_N];
  logic       m_sf = 1'b0;

  int nchk = 0;
  int nerr = 0;
  bit fin = 0;

  always #4 clk = ~clk;

  bitop_unit #(.RAM_AW(RAM_AW), .PORT_AW(PORT_AW)) uut (
    .clk(clk), .rst(rst), .start(start), .op0(op0_i), .op1(op1_i),
    .acc(acc_i), .hl(hl_i), .lr(lr_i), .busy(busy), .not_mine(not_mine),
    .info_valid(info_valid), .info_len(info_len), .info_cyc(info_cyc),
    .done(done), .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .port_re(port_re),
    .port_we(port_we), .port_addr(port_addr), .port_wdata(port_wdata),
    .port_rdata(port_rdata), .sf_we(sf_we), .sf_d(sf_d), .cf_we(cf_we),
    .zf_we(zf_we)
  );

  always @(posedge clk) begin
    ram_rdata  <= ram_mem[ram_addr];
    port_rdata <= port_mem[port_addr];
    if (ram_we)  ram_mem[ram_addr]   <= ram_wdata;
    if (port_we) port_mem[port_addr] <= port_wdata;
    if (sf_we)   sf_reg <= sf_d;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference decode: kind 0 RAM, 1 port, 2 acc; op 0 clr, 1 set, 2 inv test, 3 true test
  task automatic mdec(input logic [7:0] a, input logic [7:0] b, input int hv,
                      input logic [3:0] lv, output bit legal, output int kind,
                      output int op, output int addr, output int bx,
                      output int len, output int cyc);
    legal = 0; kind = 0; op = 0; addr = 0; bx = 0; len = 0; cyc = 0;
    if (a[7:4] == 4'hF) begin
      legal = 1; bx = int'(a[1:0]); addr = hv; len = 1; cyc = 1;
      case (a[3:2])
        2'd0: begin kind = 0; op = 0; end
        2'd1: begin kind = 0; op = 1; end
        2'd2: begin kind = 2; op = 2; end
        default: begin kind = 0; op = 2; end
      endcase
    end else if (a == 8'h6C || a == 8'h6D) begin
      legal = 1; kind = (a == 8'h6D) ? 1 : 0;
      addr = int'(b[3:0]); bx = int'(b[5:4]); len = 2; cyc = 2;
      case (b[7:6])
        2'd0: op = 2;
        2'd1: op = 1;
        2'd2: op = 3;
        default: op = 0;
      endcase
    end else if (a == 8'h60 || a == 8'h61 || a == 8'h62) begin
      legal = 1; kind = 1; addr = 4 + int'(lv[3:2]); bx = int'(lv[1:0]);
      len = 1; cyc = 2;
      op = (a == 8'h60) ? 0 : (a == 8'h62) ? 1 : 2;
    end
  endtask

  task automatic run(input string tg, input logic [7:0] a, input logic [7:0] b,
                     input logic [3:0] av, input int hv, input logic [3:0] lv,
                     input bit hold);
    bit legal; int kind, op, addr, bx, len, cyc;
    logic [3:0] srcv, nv; bit bitv, sfx, wr; int mism;
    mdec(a, b, hv, lv, legal, kind, op, addr, bx, len, cyc);
    srcv = (kind == 0) ? m_ram[addr] : (kind == 1) ? m_port[addr] : av;
    bitv = srcv[bx];
    nv = srcv; sfx = 1'b1; wr = 0;
    case (op)
      0: begin nv[bx] = 1'b0; wr = 1; end
      1: begin nv[bx] = 1'b1; wr = 1; end
      2: sfx = ~bitv;
      default: sfx = bitv;
    endcase
    @(negedge clk);
    op0_i = a; op1_i = b; acc_i = av; hl_i = RAM_AW'(hv); lr_i = lv; start = 1'b1;
    @(negedge clk);
    chk("R7", {tg, " info_valid"}, int'(info_valid), int'(legal));
    chk("R9", {tg, " not_mine"}, int'(not_mine), int'(!legal));
    chk("R8", {tg, " busy accept"}, int'(busy), int'(legal));
    chk("R8", {tg, " ram_re"}, int'(ram_re), int'(legal && kind == 0));
    chk("R8", {tg, " port_re"}, int'(port_re), int'(legal && kind == 1));
    if (legal) begin
      chk("R7", {tg, " info_len"}, int'(info_len), len);
      chk("R7", {tg, " info_cyc"}, int'(info_cyc), cyc);
      if (kind == 0) chk(tg, "ram_addr", int'(ram_addr), addr);
      if (kind == 1) chk(tg, "port_addr", int'(port_addr), addr);
    end
    if (hold) begin
      op0_i = 8'hF5; acc_i = 4'h0;
    end else start = 1'b0;
    @(negedge clk);
    chk("R8", {tg, " done early"}, int'(done), 0);
    chk("R8", {tg, " busy mid"}, int'(busy), int'(legal));
    @(negedge clk);
    start = 1'b0;
    chk("R8", {tg, " done"}, int'(done), int'(legal));
    chk("R6", {tg, " sf_we"}, int'(sf_we), int'(legal));
    if (legal) chk(tg, "sf_d", int'(sf_d), int'(sfx));
    chk("R6", {tg, " cf_we"}, int'(cf_we), 0);
    chk("R6", {tg, " zf_we"}, int'(zf_we), 0);
    chk(tg, "ram_we", int'(ram_we), int'(legal && wr && kind == 0));
    chk(tg, "port_we", int'(port_we), int'(legal && wr && kind == 1));
    if (legal && wr) begin
      chk(tg, "wdata", int'((kind == 0) ? ram_wdata : port_wdata), int'(nv));
      if (kind == 0) chk(tg, "write addr", int'(ram_addr), addr);
      if (kind == 1) chk(tg, "write port", int'(port_addr), addr);
    end
    @(negedge clk);
    if (legal && wr) begin
      if (kind == 0) m_ram[addr] = nv;
      else m_port[addr] = nv;
    end
    if (legal) m_sf = sfx;
    chk(tg, "status flag", int'(sf_reg), int'(m_sf));
    chk("R10", {tg, " busy after"}, int'(busy), 0);
    mism = 0;
    for (int i = 0; i < RAM_N; i++) if (ram_mem[i] !== m_ram[i]) mism++;
    for (int i = 0; i < PORT_N; i++) if (port_mem[i] !== m_port[i]) mism++;
    chk(tg, "memory mismatches", mism, 0);
  endtask

  initial begin
    for (int i = 0; i < RAM_N; i++) begin
      ram_mem[i] = 4'(i * 7 + 3); m_ram[i] = 4'(i * 7 + 3);
    end
    for (int i = 0; i < PORT_N; i++) begin
      port_mem[i] = 4'(i * 5 + 9); m_port[i] = 4'(i * 5 + 9);
    end
    repeat (3) @(negedge clk);
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "strobes", int'({ram_re, ram_we, port_re, port_we}), 0);
    chk("R11", "pulses", int'({done, sf_we, not_mine, info_valid}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: HL clear/set, bit 0 and 3, HL extremes, bit already at value
    m_ram[0] = 4'hF; ram_mem[0] = 4'hF;
    run("R1", 8'hF3, 8'h00, 4'h0, 0, 4'h0, 0);
    run("R1", 8'hF0, 8'h00, 4'h0, 0, 4'h0, 0);
    run("R1", 8'hF0, 8'h00, 4'h0, 0, 4'h0, 0);
    run("R1", 8'hF7, 8'h00, 4'h0, RAM_N - 1, 4'h0, 0);
    run("R1", 8'hF4, 8'h00, 4'h0, 17, 4'h0, 0);
    // R2: accumulator and RAM[HL] inverted tests
    run("R2", 8'hF9, 8'h00, 4'b1010, 0, 4'h0, 0);
    run("R2", 8'hF8, 8'h00, 4'b1010, 0, 4'h0, 0);
    run("R2", 8'hFF, 8'h00, 4'h0, RAM_N - 1, 4'h0, 0);
    run("R2", 8'hFC, 8'h00, 4'h0, 0, 4'h0, 0);
    // R3: direct RAM, all four operations
    run("R3", 8'h6C, 8'b01_10_0101, 4'h0, 0, 4'h0, 0);
    run("R3", 8'h6C, 8'b10_10_0101, 4'h0, 0, 4'h0, 0);
    run("R3", 8'h6C, 8'b00_10_0101, 4'h0, 0, 4'h0, 0);
    run("R3", 8'h6C, 8'b11_10_0101, 4'h0, 0, 4'h0, 0);
    run("R3", 8'h6C, 8'b10_10_0101, 4'h0, 0, 4'h0, 0);
    run("R3", 8'h6C, 8'b01_00_1111, 4'h0, 0, 4'h0, 0);
    // R4: direct port, all four operations
    run("R4", 8'h6D, 8'b11_11_1100, 4'h0, 0, 4'h0, 0);
    run("R4", 8'h6D, 8'b00_11_1100, 4'h0, 0, 4'h0, 0);
    run("R4", 8'h6D, 8'b01_11_1100, 4'h0, 0, 4'h0, 0);
    run("R4", 8'h6D, 8'b10_11_1100, 4'h0, 0, 4'h0, 0);
    run("R4", 8'h6D, 8'b01_00_0001, 4'h0, 0, 4'h0, 0);
    // R5: LR-indirect ports 4..7
    run("R5", 8'h62, 8'h00, 4'h0, 0, 4'b0000, 0);
    run("R5", 8'h61, 8'h00, 4'h0, 0, 4'b0000, 0);
    run("R5", 8'h60, 8'h00, 4'h0, 0, 4'b1111, 0);
    run("R5", 8'h61, 8'h00, 4'h0, 0, 4'b1111, 0);
    run("R5", 8'h62, 8'h00, 4'h0, 0, 4'b0110, 0);
    // R9: refused opcodes
    run("R9", 8'h63, 8'h00, 4'h0, 0, 4'h0, 0);
    run("R9", 8'h00, 8'h00, 4'h0, 0, 4'h0, 0);
    run("R9", 8'h6E, 8'h5A, 4'h0, 0, 4'h0, 0);
    // R10: start held through busy with another opcode
    run("R10", 8'hF1, 8'h00, 4'h0, 9, 4'h0, 1);
    run("R10", 8'h6D, 8'b11_01_0010, 4'h0, 0, 4'h0, 1);
    fin = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL R8 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule